// File: doc/BRIEF.md
# Burst-Buffered Dual-Port DMA Engine

The engine copies a programmed number of bytes from a start address on a source bus port to a start address on a separate destination bus port. The data passes through an internal staging buffer of 32 bytes. The engine fills the buffer from the source in one burst. It then gives up the source bus and asks for the destination bus, and drains the burst there. Each bus is held only for the length of one burst. The final burst of a job is shorter when the count is not a multiple of 32.

Start addresses and byte counts may be arbitrary. At the edges of a job each port uses byte and halfword accesses until its address reaches a 4-byte boundary, or until fewer than four bytes are left in the burst. Between those edges it moves full 32-bit words. The source and destination alignments are handled independently.

Software loads the source, destination and count registers and writes a start bit. It can watch busy, done and error status or wait for one of two interrupt pulses. One pulse marks normal completion. The other marks termination by a bus error or by a software abort.

Top module: `dma_burst_engine`

## Requirements
- R1: Register offsets: 0 holds the source address, 1 the destination address, 2 the byte count. Offset 3 is control and status. On write, bit 0 starts a job and bit 1 aborts one. On read, bit 0 is busy, bit 1 is done and bit 2 is error. After reset every register and status bit reads as zero.
- R2: Each burst reads min(32, remaining count) bytes from the source and then drops the source request. The destination request rises only after that. The two requests are never high in the same cycle. The next read burst starts only once the previous burst has been fully written.
- R3: Size codes are 0 for byte, 1 for halfword and 2 for word. On each port, an access is a byte when its address is odd or only one byte is left in the burst. Otherwise it is a halfword when address bit 1 is set or fewer than 4 bytes are left. Otherwise it is a word.
- R4: Lanes are little-endian: the byte at the lowest address sits in bits 7:0. Read data is taken only from the lanes the access size covers. Write lanes outside the access size are driven to zero.
- R5: The destination receives exactly the source bytes in order. Both addresses advance by the size of each completed access.
- R6: After the last write completes, busy clears, done reads as 1 and the completion interrupt pulses for one cycle.
- R7: An error response on either port while granted ends the job on the next cycle. Both requests drop, no further access is made, buffered bytes are discarded, error reads as 1 and the error interrupt pulses.
- R8: Writing the abort bit while busy ends the job in the same way as a bus error.
- R9: A start written while busy is ignored, and so are later writes to the address and count registers. The running job keeps its own copy of these values.
- R10: A start with a count of zero raises no bus request and completes at once with done set and the completion interrupt pulsed.
- R11: Done and error are both cleared by the next accepted start.
- R12: The two interrupts are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register offset |
| cfg_wdata_i | input | ADDR_W | Register write data |
| cfg_rdata_o | output | ADDR_W | Read data of the addressed register |
| rd_req_o | output | 1 | Source bus request and access valid |
| rd_gnt_i | input | 1 | Source bus grant |
| rd_addr_o | output | ADDR_W | Source access address |
| rd_size_o | output | 2 | Source access size code |
| rd_rdy_i | input | 1 | Source access complete |
| rd_err_i | input | 1 | Source access error |
| rd_rdata_i | input | 32 | Source read data |
| wr_req_o | output | 1 | Destination bus request and access valid |
| wr_gnt_i | input | 1 | Destination bus grant |
| wr_addr_o | output | ADDR_W | Destination access address |
| wr_size_o | output | 2 | Destination access size code |
| wr_wdata_o | output | 32 | Destination write data |
| wr_rdy_i | input | 1 | Destination access complete |
| wr_err_i | input | 1 | Destination access error |
| irq_done_o | output | 1 | Normal-completion pulse |
| irq_err_o | output | 1 | Error-termination pulse |

## Verification
The assertions check several properties on every cycle. Only one bus is requested at a time. Every presented access is naturally aligned for its size. An error response drops both requests and raises the error pulse on the next cycle. The interrupts stay exclusive single-cycle pulses. The bench scenarios cover what a single cycle cannot show: the byte-exact data stream across mismatched alignments, the burst lengths including a one-byte tail, discarding of buffered data after an error, and the abort, ignored-restart and zero-count cases with their status afterwards.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_t;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_ABORT = 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dma_size_pick.sv
module dma_size_pick
  import dma_pkg::*;
(
  input  logic [1:0] addr_lsb_i,
  input  logic [2:0] left_i,
  output logic [1:0] size_o,
  output logic [2:0] nbytes_o
);
  always_comb begin
    if (addr_lsb_i[0] || left_i == 3'd1) begin
      size_o   = SZ_BYTE;
      nbytes_o = 3'd1;
    end else if (addr_lsb_i[1] || left_i < 3'd4) begin
      size_o   = SZ_HALF;
      nbytes_o = 3'd2;
    end else begin
      size_o   = SZ_WORD;
      nbytes_o = 3'd4;
    end
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = IDX_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [2:0]    push_n_i,
  input  logic [31:0]   push_data_i,
  input  logic          pop_i,
  input  logic [2:0]    pop_n_i,
  output logic [CW-1:0] fill_o,
  output logic [CW-1:0] drain_o,
  output logic [31:0]   pop_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] fill_q, drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      drain_q <= '0;
    end else if (clr_i) begin
      fill_q  <= '0;
      drain_q <= '0;
    end else begin
      if (push_i) fill_q  <= fill_q + CW'(push_n_i);
      if (pop_i)  drain_q <= drain_q + CW'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < push_n_i)
          mem_q[fill_q[IDX_W-1:0] + IDX_W'(k)] <= push_data_i[8*k +: 8];
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign pop_data_o[8*k +: 8] = mem_q[drain_q[IDX_W-1:0] + IDX_W'(k)];
  end

  assign fill_o  = fill_q;
  assign drain_o = drain_q;
endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BURST  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  output logic              rd_req_o,
  input  logic              rd_gnt_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [1:0]        rd_size_o,
  input  logic              rd_rdy_i,
  input  logic              rd_err_i,
  input  logic [31:0]       rd_rdata_i,
  output logic              wr_req_o,
  input  logic              wr_gnt_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [1:0]        wr_size_o,
  output logic [31:0]       wr_wdata_o,
  input  logic              wr_rdy_i,
  input  logic              wr_err_i,
  output logic              irq_done_o,
  output logic              irq_err_o
);
  localparam int BI_W = $clog2(BURST) + 1;

  dma_state_t        state_q;
  logic [ADDR_W-1:0] cfg_src_q, cfg_dst_q, src_q, dst_q;
  logic [CNT_W-1:0]  cfg_cnt_q, rem_q;
  logic              done_q, err_q, irq_done_q, irq_err_q;

  logic [BI_W-1:0] fill, drain, room, avail;
  logic [2:0]      rd_lim, wr_lim, rd_n, wr_n;
  logic [31:0]     pop_data;
  logic            ctrl_wr, start, abort;
  logic            rd_fire, rd_ok, rd_bad, rd_last;
  logic            wr_fire, wr_ok, wr_bad, wr_last, buf_clr;

  assign room  = BI_W'(BURST) - fill;
  assign avail = fill - drain;

  // clamp per-access byte budget to 4
  always_comb begin
    rd_lim = 3'd4;
    if (rem_q < CNT_W'(4)) rd_lim = rem_q[2:0];
    if (room < BI_W'(4) && room[2:0] < rd_lim) rd_lim = room[2:0];
    wr_lim = (avail < BI_W'(4)) ? avail[2:0] : 3'd4;
  end

  dma_size_pick u_rd_pick (
    .addr_lsb_i (src_q[1:0]),
    .left_i     (rd_lim),
    .size_o     (rd_size_o),
    .nbytes_o   (rd_n)
  );

  dma_size_pick u_wr_pick (
    .addr_lsb_i (dst_q[1:0]),
    .left_i     (wr_lim),
    .size_o     (wr_size_o),
    .nbytes_o   (wr_n)
  );

  assign ctrl_wr = cfg_we_i && (cfg_addr_i == REG_CTRL);
  assign start   = ctrl_wr && cfg_wdata_i[CTRL_START];
  assign abort   = ctrl_wr && cfg_wdata_i[CTRL_ABORT];

  assign rd_fire = (state_q == ST_RD) && rd_gnt_i;
  assign rd_ok   = rd_fire && rd_rdy_i && !rd_err_i;
  assign rd_bad  = rd_fire && rd_err_i;
  assign rd_last = rd_ok && ((fill + BI_W'(rd_n) == BI_W'(BURST)) || (rem_q == CNT_W'(rd_n)));

  assign wr_fire = (state_q == ST_WR) && wr_gnt_i;
  assign wr_ok   = wr_fire && wr_rdy_i && !wr_err_i;
  assign wr_bad  = wr_fire && wr_err_i;
  assign wr_last = wr_ok && (drain + BI_W'(wr_n) == fill);

  assign buf_clr = (state_q == ST_IDLE) || wr_last;

  dma_burst_buf #(.DEPTH(BURST)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (buf_clr),
    .push_i      (rd_ok),
    .push_n_i    (rd_n),
    .push_data_i (rd_rdata_i),
    .pop_i       (wr_ok),
    .pop_n_i     (wr_n),
    .fill_o      (fill),
    .drain_o     (drain),
    .pop_data_o  (pop_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_src_q  <= '0;
      cfg_dst_q  <= '0;
      cfg_cnt_q  <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      rem_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
      if (cfg_we_i) begin
        case (cfg_addr_i)
          REG_SRC: cfg_src_q <= cfg_wdata_i;
          REG_DST: cfg_dst_q <= cfg_wdata_i;
          REG_CNT: cfg_cnt_q <= cfg_wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
      if (state_q == ST_IDLE) begin
        if (start) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          src_q  <= cfg_src_q;
          dst_q  <= cfg_dst_q;
          rem_q  <= cfg_cnt_q;
          if (cfg_cnt_q == '0) begin
            done_q     <= 1'b1;
            irq_done_q <= 1'b1;
          end else begin
            state_q <= ST_RD;
          end
        end
      end else if (abort || rd_bad || wr_bad) begin
        state_q   <= ST_IDLE;
        err_q     <= 1'b1;
        irq_err_q <= 1'b1;
      end else if (rd_ok) begin
        src_q <= src_q + ADDR_W'(rd_n);
        rem_q <= rem_q - CNT_W'(rd_n);
        if (rd_last) state_q <= ST_WR;
      end else if (wr_ok) begin
        dst_q <= dst_q + ADDR_W'(wr_n);
        if (wr_last) begin
          if (rem_q == '0) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            irq_done_q <= 1'b1;
          end else begin
            state_q <= ST_RD;
          end
        end
      end
    end
  end

  always_comb begin
    case (cfg_addr_i)
      REG_SRC: cfg_rdata_o = cfg_src_q;
      REG_DST: cfg_rdata_o = cfg_dst_q;
      REG_CNT: cfg_rdata_o = ADDR_W'(cfg_cnt_q);
      default: cfg_rdata_o = ADDR_W'({err_q, done_q, state_q != ST_IDLE});
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_wlane
    assign wr_wdata_o[8*k +: 8] = (3'(k) < wr_n) ? pop_data[8*k +: 8] : 8'h00;
  end

  assign rd_req_o   = (state_q == ST_RD);
  assign wr_req_o   = (state_q == ST_WR);
  assign rd_addr_o  = src_q;
  assign wr_addr_o  = dst_q;
  assign irq_done_o = irq_done_q;
  assign irq_err_o  = irq_err_q;
endmodule

// File: rtl/dma_burst_chk.sv
module dma_burst_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic              rd_gnt_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [1:0]        rd_size_o,
  input logic              rd_err_i,
  input logic              wr_req_o,
  input logic              wr_gnt_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [1:0]        wr_size_o,
  input logic              wr_err_i,
  input logic              irq_done_o,
  input logic              irq_err_o
);
  p_one_owner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  p_rd_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_size_o != 2'd3) && !(rd_size_o == 2'd2 && rd_addr_o[1:0] != 2'd0)
                 && !(rd_size_o == 2'd1 && rd_addr_o[0]));

  p_wr_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_size_o != 2'd3) && !(wr_size_o == 2'd2 && wr_addr_o[1:0] != 2'd0)
                 && !(wr_size_o == 2'd1 && wr_addr_o[0]));

  p_rd_err_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_gnt_i && rd_err_i) |=> (!rd_req_o && !wr_req_o && irq_err_o));

  p_wr_err_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_gnt_i && wr_err_i) |=> (!rd_req_o && !wr_req_o && irq_err_o));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> (!rd_req_o && !wr_req_o));

  p_irq_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_done_o && irq_err_o));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o);

  p_err_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |=> !irq_err_o);
endmodule

bind dma_burst_engine dma_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_gnt_i   (rd_gnt_i),
  .rd_addr_o  (rd_addr_o),
  .rd_size_o  (rd_size_o),
  .rd_err_i   (rd_err_i),
  .wr_req_o   (wr_req_o),
  .wr_gnt_i   (wr_gnt_i),
  .wr_addr_o  (wr_addr_o),
  .wr_size_o  (wr_size_o),
  .wr_err_i   (wr_err_i),
  .irq_done_o (irq_done_o),
  .irq_err_o  (irq_err_o)
);

// File: tb/tb_dma_burst_engine.sv
module tb_dma_burst_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = 2'd3;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        rd_req_o, rd_gnt_i, rd_rdy_i, rd_err_i;
  logic [31:0] rd_addr_o, rd_rdata_i;
  logic [1:0]  rd_size_o;
  logic        wr_req_o, wr_gnt_i, wr_rdy_i, wr_err_i;
  logic [31:0] wr_addr_o, wr_wdata_o;
  logic [1:0]  wr_size_o;
  logic        irq_done_o, irq_err_o;

  always #5 clk_i = ~clk_i;

  dma_burst_engine dut (.*);

  int checks = 0, errors = 0;
  int m_src, m_dst, m_rem, m_fill, m_drain, m_blen;
  logic [7:0] q[$];
  int rd_acc, wr_acc, wr_bytes, irq_d, irq_e, cyc;
  int inj_rd = -1, inj_wr = -1, stall_mod = 0;
  bit prev_rd = 0, prev_wr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(int a);
    return 8'((a * 13) + (a >> 8));
  endfunction

  function automatic int pick_n(int a, int left);
    if ((a % 2) == 1 || left == 1) return 1;
    if (((a / 2) % 2) == 1 || left < 4) return 2;
    return 4;
  endfunction

  function automatic int code_of(int n);
    return (n == 1) ? 0 : (n == 2) ? 1 : 2;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // bus slaves and reference model, evaluated once per clock
  initial begin
    rd_gnt_i = 0; rd_rdy_i = 0; rd_err_i = 0; rd_rdata_i = '0;
    wr_gnt_i = 0; wr_rdy_i = 0; wr_err_i = 0;
    cyc = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      if (irq_done_o) irq_d++;
      if (irq_err_o)  irq_e++;
      chk(!(rd_req_o && wr_req_o), "R2", "both requests high", {rd_req_o, wr_req_o}, 0);
      chk(!(irq_done_o && irq_err_o), "R12", "both interrupts high", {irq_done_o, irq_err_o}, 0);
      if (rd_req_o && !prev_rd) begin
        chk(q.size() == 0, "R2", "buffer not drained before read burst", q.size(), 0);
        m_fill = 0; m_drain = 0; m_blen = min2(32, m_rem);
      end
      if (wr_req_o && !prev_wr)
        chk(m_fill == m_blen, "R2", "bytes read before write burst", m_fill, m_blen);
      prev_rd = rd_req_o;
      prev_wr = wr_req_o;

      rd_rdy_i = 0; rd_err_i = 0; rd_gnt_i = rd_req_o; rd_rdata_i = 32'hEEEE_EEEE;
      wr_rdy_i = 0; wr_err_i = 0; wr_gnt_i = wr_req_o;
      if (stall_mod == 0 || (cyc % stall_mod) != 0) begin
        if (rd_req_o) begin
          int n;
          n = pick_n(m_src, min2(m_rem, 32 - m_fill));
          chk(rd_addr_o == 32'(m_src), "R5", "read address", rd_addr_o, m_src);
          chk(rd_size_o == 2'(code_of(n)), "R3", "read size", rd_size_o, code_of(n));
          if (rd_acc == inj_rd) rd_err_i = 1;
          else begin
            rd_rdy_i = 1;
            for (int k = 0; k < n; k++) begin
              rd_rdata_i[8*k +: 8] = sb(m_src + k);
              q.push_back(sb(m_src + k));
            end
          end
          m_src += n; m_rem -= n; m_fill += n; rd_acc++;
        end
        if (wr_req_o) begin
          int n;
          logic [31:0] expw;
          n = pick_n(m_dst, m_fill - m_drain);
          chk(wr_addr_o == 32'(m_dst), "R5", "write address", wr_addr_o, m_dst);
          chk(wr_size_o == 2'(code_of(n)), "R3", "write size", wr_size_o, code_of(n));
          expw = '0;
          for (int k = 0; k < n; k++) if (k < q.size()) expw[8*k +: 8] = q[k];
          chk(wr_wdata_o == expw, "R4", "write data lanes", wr_wdata_o, expw);
          if (wr_acc == inj_wr) wr_err_i = 1;
          else begin
            wr_rdy_i = 1;
            for (int k = 0; k < n; k++) if (q.size() > 0) void'(q.pop_front());
            wr_bytes += n;
          end
          m_dst += n; m_drain += n; wr_acc++;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0; cfg_addr_i = 2'd3; cfg_wdata_i = '0;
  endtask

  // mode: 0 plain, 1 abort at cycle 'at', 2 re-program and restart at cycle 'at'
  task automatic run_job(input int src, input int dst, input int cnt, input int ird,
                         input int iwr, input int mode, input int at, input int smod);
    int t;
    m_src = src; m_dst = dst; m_rem = cnt; m_fill = 0; m_drain = 0; m_blen = 0;
    q.delete();
    rd_acc = 0; wr_acc = 0; wr_bytes = 0; irq_d = 0; irq_e = 0;
    inj_rd = ird; inj_wr = iwr; stall_mod = smod;
    cfg_write(2'd0, 32'(src));
    cfg_write(2'd1, 32'(dst));
    cfg_write(2'd2, 32'(cnt));
    cfg_write(2'd3, 32'h1);
    t = 0;
    while (irq_d == 0 && irq_e == 0 && t < 4000) begin
      if (mode == 1 && t == at) cfg_write(2'd3, 32'h2);
      else if (mode == 2 && t == at) begin
        cfg_write(2'd2, 32'd8);
        cfg_write(2'd0, 32'h7000);
        cfg_write(2'd3, 32'h1);
      end else @(negedge clk_i);
      t++;
    end
    chk(t < 4000, "R6", "job did not terminate", t, 4000);
    repeat (4) @(negedge clk_i);
    q.delete();
  endtask

  task automatic expect_quiet(input string req);
    int snap;
    snap = rd_acc + wr_acc;
    repeat (6) @(negedge clk_i);
    chk(rd_acc + wr_acc == snap, req, "access after termination", rd_acc + wr_acc, snap);
    chk(!rd_req_o && !wr_req_o, req, "request after termination", {rd_req_o, wr_req_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cfg_rdata_o == 0, "R1", "status after reset", cfg_rdata_o, 0);
    chk(!rd_req_o && !wr_req_o, "R1", "requests after reset", {rd_req_o, wr_req_o}, 0);
    chk(!irq_done_o && !irq_err_o, "R1", "interrupts after reset", {irq_done_o, irq_err_o}, 0);
    rst_ni = 1;
    cfg_write(2'd0, 32'h1234_5678);
    cfg_addr_i = 2'd0;
    @(negedge clk_i);
    chk(cfg_rdata_o == 32'h1234_5678, "R1", "source register readback", cfg_rdata_o, 32'h1234_5678);
    cfg_addr_i = 2'd3;

    // aligned, two full bursts, all words
    run_job(32'h100, 32'h2000, 64, -1, -1, 0, 0, 0);
    chk(irq_d == 1 && irq_e == 0, "R6", "completion pulse count", irq_d, 1);
    chk(wr_bytes == 64, "R5", "bytes written aligned", wr_bytes, 64);
    chk(rd_acc == 16, "R3", "word reads for aligned job", rd_acc, 16);
    chk(cfg_rdata_o == 32'h2, "R6", "status after completion", cfg_rdata_o, 2);

    // mismatched unaligned ends with stalls
    run_job(32'h1003, 32'h2001, 45, -1, -1, 0, 0, 3);
    chk(irq_d == 1, "R6", "completion unaligned", irq_d, 1);
    chk(wr_bytes == 45, "R5", "bytes written unaligned", wr_bytes, 45);

    // tiny odd job
    run_job(32'h1001, 32'h3002, 3, -1, -1, 0, 0, 2);
    chk(wr_bytes == 3, "R5", "bytes written tiny", wr_bytes, 3);
    chk(rd_acc == 2, "R3", "byte then half read", rd_acc, 2);

    // word-aligned source, odd destination
    run_job(32'h2000, 32'h3003, 37, -1, -1, 0, 0, 0);
    chk(wr_bytes == 37, "R5", "bytes written odd destination", wr_bytes, 37);

    // zero count
    run_job(32'h100, 32'h200, 0, -1, -1, 0, 0, 0);
    chk(rd_acc == 0 && wr_acc == 0, "R10", "bus access for zero count", rd_acc + wr_acc, 0);
    chk(irq_d == 1, "R10", "completion for zero count", irq_d, 1);
    chk(cfg_rdata_o == 32'h2, "R10", "status for zero count", cfg_rdata_o, 2);

    // read error in first burst
    run_job(32'h400, 32'h500, 100, 3, -1, 0, 0, 0);
    chk(irq_e == 1 && irq_d == 0, "R7", "error pulse on read error", irq_e, 1);
    chk(wr_acc == 0, "R7", "buffered bytes written after read error", wr_acc, 0);
    chk(cfg_rdata_o == 32'h4, "R7", "status after read error", cfg_rdata_o, 4);
    expect_quiet("R7");

    // next job clears error; one-byte tail burst
    run_job(32'h600, 32'h800, 33, -1, -1, 0, 0, 2);
    chk(cfg_rdata_o == 32'h2, "R11", "status after job following error", cfg_rdata_o, 2);
    chk(wr_bytes == 33, "R2", "bytes with short tail burst", wr_bytes, 33);

    // write error
    run_job(32'h900, 32'hA00, 70, -1, 2, 0, 0, 0);
    chk(irq_e == 1 && irq_d == 0, "R7", "error pulse on write error", irq_e, 1);
    chk(cfg_rdata_o == 32'h4, "R7", "status after write error", cfg_rdata_o, 4);
    expect_quiet("R7");

    // software abort
    run_job(32'hB00, 32'hC00, 200, -1, -1, 1, 10, 2);
    chk(irq_e == 1 && irq_d == 0, "R8", "error pulse on abort", irq_e, 1);
    chk(wr_bytes < 200, "R8", "abort stopped job early", wr_bytes, 200);
    chk(cfg_rdata_o == 32'h4, "R8", "status after abort", cfg_rdata_o, 4);
    expect_quiet("R8");

    // start while busy is ignored
    run_job(32'hD01, 32'hE00, 40, -1, -1, 2, 6, 0);
    chk(wr_bytes == 40, "R9", "job length after ignored restart", wr_bytes, 40);
    chk(irq_d == 1, "R9", "single completion after ignored restart", irq_d, 1);
    chk(cfg_rdata_o == 32'h2, "R11", "status after completion clears error", cfg_rdata_o, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule